// File: doc/BRIEF.md
# Sync Activity Detector and Source Selector

This block watches three sync sources of a video front end: a separate horizontal sync line, a separate vertical sync line, and the digital output of a sync-on-green slicer. For each source it keeps an activity flag. It then picks which source downstream timing logic should lock to. All three inputs are asynchronous. Each one is brought into the reference clock domain through a two-flop synchronizer, and the block then looks for edges.

A separate sync line counts as active as soon as it toggles. Sync-on-green is harder to trust, because ordinary video with a repeating pattern can look like sync. For that input the block measures every pulse in reference-clock cycles: the rise-to-rise period and the high time. It declares activity only after a long unbroken run of pulses whose timing agrees with the pulse before. When both horizontal sync and sync-on-green are active, both flags stay set, but the selector always takes horizontal sync. A separate qualified output shows when the sync-on-green indication can be relied on.

The logic has no enable and no gating. It runs whenever the reference clock runs, so a system that is otherwise powered down can still use it to find valid video.

Top module: `sync_activity_top`

## Requirements
- R1: After reset, hs_active, vs_active, sog_active and sog_valid are 0 and sync_sel is 2'b00.
- R2: A rising or falling edge on hs_in sets hs_active within four reference-clock cycles. The same holds for vs_in and vs_active. An edge seen in one cycle is reflected in the flag in the next.
- R3: A flag clears when its input has shown no edge for 2^TIMEOUT_W reference-clock cycles (TIMEOUT_W defaults to 16). Until then it stays set.
- R4: A sync-on-green pulse is measured at the rising edge that ends it. Its period is the number of cycles from its own rising edge to that edge, and its high time is the number of cycles it stayed high.
- R5: A measured pulse matches the previous measured pulse when both period and high time differ by at most TOL cycles (default 2). The first measurement after reset or after a timeout has no predecessor and starts the run count at 0.
- R6: A pulse that does not match resets the run count to 0. If sog_active was set, it clears on that pulse.
- R7: The run count goes up by one for each matching pulse and saturates at RUN (default 64). sog_active is 1 exactly when the count equals RUN. With RUN=64, 65 identical pulses followed by a rising edge set the flag, and 64 pulses do not.
- R8: sync_sel is 2'b01 when hs_active is 1. It is 2'b10 when hs_active is 0 and sog_active is 1, and 2'b00 otherwise. Vertical sync activity never changes sync_sel.
- R9: sog_valid equals sog_active and not hs_active. Both hs_active and sog_active can be 1 at the same time.
- R10: A sync-on-green timeout clears the run count and the stored measurements, so that a new run starts from R5's first-measurement case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hs_in | input | 1 | Separate horizontal (or composite) sync, asynchronous |
| vs_in | input | 1 | Separate vertical sync, asynchronous |
| sog_in | input | 1 | Sliced sync-on-green, asynchronous |
| hs_active | output | 1 | Horizontal sync activity flag |
| vs_active | output | 1 | Vertical sync activity flag |
| sog_active | output | 1 | Sync-on-green run of matching pulses reached |
| sog_valid | output | 1 | Sync-on-green activity with no horizontal sync |
| sync_sel | output | 2 | Chosen source: 00 none, 01 horizontal, 10 sync-on-green |

## Verification
The hardest state to reach is the exact edge of the run length. The flag must appear on the 64th consecutive match and not on the 63rd, and a single pulse just outside tolerance must bring it down. The bench drives directed pulse trains of exactly 64 and 65 pulses, trains whose period alternates by exactly TOL and by TOL+1, and one mismatched pulse after a saturated run. Random trains with per-pulse jitter are then checked against a bench model of the match count. A concurrent train of horizontal and sync-on-green pulses covers the priority case where both flags are set.

// File: rtl/sync_det_pkg.sv
package sync_det_pkg;

    typedef enum logic [1:0] {
        SRC_NONE = 2'b00,
        SRC_HS   = 2'b01,
        SRC_SOG  = 2'b10
    } src_sel_e;

    function automatic logic within_tol(input logic [15:0] a,
                                        input logic [15:0] b,
                                        input logic [15:0] tol);
        logic [15:0] diff;
        diff = (a >= b) ? (a - b) : (b - a);
        return diff <= tol;
    endfunction

endpackage

// File: rtl/sda_sync_edge.sv
module sda_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise_o,
    output logic fall_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = din;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = st_q.s2 & ~st_q.prev;
    assign fall_o = ~st_q.s2 & st_q.prev;
endmodule

// File: rtl/sda_idle_timer.sv
module sda_idle_timer #(
    parameter int TIMEOUT_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_i,
    output logic active_o
);
    localparam logic [TIMEOUT_W-1:0] LIMIT = '1;

    typedef struct packed {
        logic [TIMEOUT_W-1:0] cnt;
        logic                 act;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (edge_i) begin
            st_d.cnt = '0;
            st_d.act = 1'b1;
        end else if (st_q.act) begin
            if (st_q.cnt == LIMIT) begin
                st_d.act = 1'b0;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active_o = st_q.act;
endmodule

// File: rtl/sda_pulse_qual.sv
module sda_pulse_qual
    import sync_det_pkg::*;
#(
    parameter int MEAS_W = 12,
    parameter int TOL    = 2,
    parameter int RUN    = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_i,
    input  logic fall_i,
    input  logic alive_i,
    output logic active_o
);
    localparam int MW = $clog2(RUN + 1);
    localparam logic [MEAS_W-1:0] MAXV  = '1;
    localparam logic [MW-1:0]     RUN_V = MW'(RUN);
    localparam logic [15:0]       TOL_V = 16'(TOL);

    typedef struct packed {
        logic [MEAS_W-1:0] per_cnt;
        logic [MEAS_W-1:0] hi_cnt;
        logic [MEAS_W-1:0] hi_meas;
        logic [MEAS_W-1:0] prev_per;
        logic [MEAS_W-1:0] prev_hi;
        logic              in_high;
        logic              have_rise;
        logic              have_meas;
        logic [MW-1:0]     match;
    } st_t;

    st_t st_d, st_q;
    logic same_per, same_hi;

    always_comb begin
        same_per = within_tol(16'(st_q.per_cnt), 16'(st_q.prev_per), TOL_V);
        same_hi  = within_tol(16'(st_q.hi_meas), 16'(st_q.prev_hi),  TOL_V);
    end

    always_comb begin
        st_d = st_q;
        if (st_q.per_cnt != MAXV) st_d.per_cnt = st_q.per_cnt + 1'b1;
        if (st_q.in_high && st_q.hi_cnt != MAXV) st_d.hi_cnt = st_q.hi_cnt + 1'b1;

        if (fall_i) begin
            st_d.hi_meas = st_q.hi_cnt;
            st_d.in_high = 1'b0;
        end

        if (rise_i) begin
            if (st_q.have_rise) begin
                if (st_q.have_meas && same_per && same_hi) begin
                    if (st_q.match != RUN_V) st_d.match = st_q.match + 1'b1;
                end else begin
                    st_d.match = '0;
                end
                st_d.prev_per  = st_q.per_cnt;
                st_d.prev_hi   = st_q.hi_meas;
                st_d.have_meas = 1'b1;
            end
            st_d.have_rise = 1'b1;
            st_d.in_high   = 1'b1;
            st_d.per_cnt   = MEAS_W'(1);
            st_d.hi_cnt    = MEAS_W'(1);
        end else if (!alive_i) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active_o = (st_q.match == RUN_V);
endmodule

// File: rtl/sync_activity_top.sv
module sync_activity_top
    import sync_det_pkg::*;
#(
    parameter int TIMEOUT_W = 16,
    parameter int MEAS_W    = 12,
    parameter int TOL       = 2,
    parameter int RUN       = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hs_in,
    input  logic       vs_in,
    input  logic       sog_in,
    output logic       hs_active,
    output logic       vs_active,
    output logic       sog_active,
    output logic       sog_valid,
    output logic [1:0] sync_sel
);
    logic hs_rise, hs_fall, vs_rise, vs_fall, sog_rise, sog_fall;
    logic hs_edge, vs_edge, sog_edge, sog_alive;
    src_sel_e sel;

    sda_sync_edge u_hs_sync  (.clk(clk), .rst_n(rst_n), .din(hs_in),  .rise_o(hs_rise),  .fall_o(hs_fall));
    sda_sync_edge u_vs_sync  (.clk(clk), .rst_n(rst_n), .din(vs_in),  .rise_o(vs_rise),  .fall_o(vs_fall));
    sda_sync_edge u_sog_sync (.clk(clk), .rst_n(rst_n), .din(sog_in), .rise_o(sog_rise), .fall_o(sog_fall));

    assign hs_edge  = hs_rise  | hs_fall;
    assign vs_edge  = vs_rise  | vs_fall;
    assign sog_edge = sog_rise | sog_fall;

    sda_idle_timer #(.TIMEOUT_W(TIMEOUT_W)) u_hs_tmr  (.clk(clk), .rst_n(rst_n), .edge_i(hs_edge),  .active_o(hs_active));
    sda_idle_timer #(.TIMEOUT_W(TIMEOUT_W)) u_vs_tmr  (.clk(clk), .rst_n(rst_n), .edge_i(vs_edge),  .active_o(vs_active));
    sda_idle_timer #(.TIMEOUT_W(TIMEOUT_W)) u_sog_tmr (.clk(clk), .rst_n(rst_n), .edge_i(sog_edge), .active_o(sog_alive));

    sda_pulse_qual #(.MEAS_W(MEAS_W), .TOL(TOL), .RUN(RUN)) u_qual (
        .clk(clk), .rst_n(rst_n), .rise_i(sog_rise), .fall_i(sog_fall),
        .alive_i(sog_alive), .active_o(sog_active)
    );

    always_comb begin
        if (hs_active)       sel = SRC_HS;
        else if (sog_active) sel = SRC_SOG;
        else                 sel = SRC_NONE;
    end

    assign sync_sel  = sel;
    assign sog_valid = sog_active & ~hs_active;
endmodule

// File: rtl/sda_checker.sv
module sda_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       hs_active,
    input logic       vs_active,
    input logic       sog_active,
    input logic       sog_valid,
    input logic [1:0] sync_sel,
    input logic       hs_edge,
    input logic       vs_edge
);
    AST_HS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        hs_active |-> sync_sel == 2'b01) else $error("hs priority"); // R8
    AST_SOG_PICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!hs_active && sog_active) |-> sync_sel == 2'b10) else $error("sog pick"); // R8
    AST_NONE_PICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!hs_active && !sog_active) |-> sync_sel == 2'b00) else $error("none pick"); // R8
    AST_SOG_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        sog_valid |-> (sog_active && !hs_active)) else $error("sog qual"); // R9
    AST_HS_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        hs_edge |=> hs_active) else $error("hs set"); // R2
    AST_VS_NO_EARLY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vs_active) |-> !$past(vs_edge)) else $error("vs drop"); // R3
endmodule

bind sync_activity_top sda_checker u_sda_checker (
    .clk(clk), .rst_n(rst_n), .hs_active(hs_active), .vs_active(vs_active),
    .sog_active(sog_active), .sog_valid(sog_valid), .sync_sel(sync_sel),
    .hs_edge(hs_edge), .vs_edge(vs_edge)
);

// File: tb/test_sync_activity_top.sv
`timescale 1ns/1ps
module test_sync_activity_top;
    localparam int TW  = 10;
    localparam int TOL = 2;
    localparam int RUN = 64;

    logic clk = 1'b0;
    logic rst_n, hs_in, vs_in, sog_in;
    logic hs_active, vs_active, sog_active, sog_valid;
    logic [1:0] sync_sel;

    int n_chk = 0;
    int n_bad = 0;
    int hh[200];
    int ll[200];
    int npl;

    always #2.5 clk = ~clk;

    sync_activity_top #(.TIMEOUT_W(TW), .MEAS_W(12), .TOL(TOL), .RUN(RUN)) i_sync_activity_top (
        .clk(clk), .rst_n(rst_n), .hs_in(hs_in), .vs_in(vs_in), .sog_in(sog_in),
        .hs_active(hs_active), .vs_active(vs_active), .sog_active(sog_active),
        .sog_valid(sog_valid), .sync_sel(sync_sel)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int urange(input int lo, input int hi);
        return lo + int'($urandom % (hi - lo + 1));
    endfunction

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    // Model of R4..R7: pulse k measured at following rise; final rise closes the last pulse
    function automatic int model_active();
        int cnt = 0;
        for (int k = 1; k < npl; k++) begin
            if (iabs((hh[k]+ll[k]) - (hh[k-1]+ll[k-1])) <= TOL && iabs(hh[k]-hh[k-1]) <= TOL) begin
                if (cnt < RUN) cnt++;
            end else cnt = 0;
        end
        return (cnt == RUN) ? 1 : 0;
    endfunction

    task automatic pulse_sog(input int h, input int l);
        sog_in = 1'b1; repeat (h) @(negedge clk);
        sog_in = 1'b0; repeat (l) @(negedge clk);
    endtask

    task automatic run_seq(input string tag);
        int e;
        for (int i = 0; i < npl; i++) pulse_sog(hh[i], ll[i]);
        sog_in = 1'b1; repeat (3) @(negedge clk);
        sog_in = 1'b0; repeat (3) @(negedge clk);
        e = model_active();
        chk({tag, " R7 sog_active"}, sog_active, e);
        chk({tag, " R9 sog_valid"}, sog_valid, e);
        chk({tag, " R8 sync_sel"}, sync_sel, e ? 2 : 0);
        repeat (1000) @(negedge clk);
        chk({tag, " R3 hold before timeout"}, sog_active, e);
        repeat (100) @(negedge clk);
        chk({tag, " R10 cleared after timeout"}, sog_active, 0);
        chk({tag, " R8 sel after timeout"}, sync_sel, 0);
    endtask

    task automatic fill(input int n, input int h, input int l0, input int l1);
        npl = n;
        for (int i = 0; i < n; i++) begin
            hh[i] = h;
            ll[i] = (i % 2 == 0) ? l0 : l1;
        end
    endtask

    initial begin
        for (int c = 0; c < 190000; c++) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 1'b0; hs_in = 1'b0; vs_in = 1'b0; sog_in = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 hs_active", hs_active, 0);
        chk("R1 vs_active", vs_active, 0);
        chk("R1 sog_active", sog_active, 0);
        chk("R1 sog_valid", sog_valid, 0);
        chk("R1 sync_sel", sync_sel, 0);

        // R2 / R8: horizontal sync only
        for (int i = 0; i < 4; i++) begin
            hs_in = 1'b1; repeat (10) @(negedge clk);
            hs_in = 1'b0; repeat (40) @(negedge clk);
        end
        chk("R2 hs_active", hs_active, 1);
        chk("R8 sel hs", sync_sel, 1);
        chk("R2 vs_active untouched", vs_active, 0);
        repeat (900) @(negedge clk);
        chk("R3 hs still set", hs_active, 1);
        repeat (200) @(negedge clk);
        chk("R3 hs timed out", hs_active, 0);
        chk("R8 sel none", sync_sel, 0);

        // R2 / R8: vertical sync never selects
        vs_in = 1'b1; repeat (20) @(negedge clk);
        vs_in = 1'b0; repeat (5) @(negedge clk);
        chk("R2 vs_active", vs_active, 1);
        chk("R8 vs no select", sync_sel, 0);
        repeat (1100) @(negedge clk);
        chk("R3 vs timed out", vs_active, 0);

        // R7 boundary: 65 pulses set, 64 do not
        fill(65, 5, 15, 15); run_seq("R7 65 pulses");
        chk("R7 65 model", model_active(), 1);
        fill(64, 5, 15, 15); run_seq("R7 64 pulses");
        // R5 tolerance boundary
        fill(80, 5, 15, 17); run_seq("R5 diff 2");
        fill(80, 5, 15, 18); run_seq("R5 diff 3");
        fill(80, 5, 15, 15); hh[79] = 8; ll[79] = 12; run_seq("R5 high diff 3");
        // R6 mismatch after saturation
        fill(90, 6, 14, 14); hh[85] = 6; ll[85] = 20; run_seq("R6 late mismatch");

        // R8 / R9: both active, horizontal wins
        fork
            for (int i = 0; i < 80; i++) pulse_sog(5, 15);
            for (int i = 0; i < 10; i++) begin
                hs_in = 1'b1; repeat (10) @(negedge clk);
                hs_in = 1'b0; repeat (90) @(negedge clk);
            end
        join
        chk("R9 both hs", hs_active, 1);
        chk("R9 both sog", sog_active, 1);
        chk("R8 hs over sog", sync_sel, 1);
        chk("R9 sog not valid", sog_valid, 0);
        for (int i = 0; i < 80; i++) pulse_sog(5, 15);
        chk("R3 hs dropped", hs_active, 0);
        chk("R8 sog selected", sync_sel, 2);
        chk("R9 sog valid", sog_valid, 1);
        repeat (1100) @(negedge clk);
        chk("R10 all idle", sog_active, 0);

        // Random trains
        for (int s = 0; s < 20; s++) begin
            int base_h, base_l, mode;
            base_h = urange(3, 12);
            base_l = urange(4, 28);
            mode   = urange(0, 2);
            npl    = urange(60, 80);
            for (int i = 0; i < npl; i++) begin
                case (mode)
                    0: begin hh[i] = base_h; ll[i] = base_l; end
                    1: begin hh[i] = base_h + urange(0, 1); ll[i] = base_l + urange(0, 1); end
                    default: begin hh[i] = base_h + urange(0, 2); ll[i] = base_l + urange(0, 3); end
                endcase
            end
            if (urange(0, 3) == 0) ll[urange(30, npl - 1)] = base_l + 9;
            run_seq("R4 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule